// File: doc/BRIEF.md
# CAN Bit Timing and Sampler

This block divides the module clock into time quanta and splits each nominal CAN bit into a one-quantum sync segment, a first time segment and a second time segment. At the end of the first segment it resolves the received bit value. It either takes the bus level at that instant or takes a majority vote over three samples spaced one quantum apart. It gives a one-cycle strobe carrying the resolved bit and a second strobe at the end of every bit time. An external start-of-bit strobe restarts the quantum divider and the segment position. Edge resynchronization is done elsewhere.

Two configuration registers control the timing. One holds the prescaler and the other holds the sampling mode and both segment lengths. Either register can be read at any time. Writes take effect only while the controller both requests and acknowledges initialization mode.

Top module: `can_bit_sampler`

## Requirements
- R1: After reset both configuration registers read 0. With these values the quantum tick fires on every cycle and a bit lasts 3 quanta.
- R2: A write on `cfg_wr` updates the register selected by `cfg_sel` only when `init_req` and `init_ack` are both 1. Any other write leaves both registers unchanged. `cfg_rdata` shows the selected register on every cycle.
- R3: `cfg_sel`=0 selects the prescaler register, whose value P sits in bits 5:0 and whose bits 7:6 read 0. `cfg_sel`=1 selects the timing register, which holds the sampling mode in bit 7, T2 in bits 6:4 and T1 in bits 3:0.
- R4: `tq_tick` is high for one cycle out of every P+1 cycles, so the time quantum is P+1 clock cycles.
- R5: Quanta are numbered from 0 (the sync quantum) within the bit. A bit lasts 3+T1+T2 quanta. `bit_end` pulses with the tick that ends the last quantum, and numbering then restarts at 0.
- R6: `sample_valid` pulses with the tick that ends quantum T1+1, which is the end of the first segment (T1+1 quanta long).
- R7: With the sampling mode bit at 0, `sample_bit` equals `rx_in` in the `sample_valid` cycle.
- R8: With the sampling mode bit at 1, `sample_bit` is the majority of `rx_in` taken at the ticks ending quanta T1-1, T1 and T1+1.
- R9: `cfg_err` is 1 exactly when the sampling mode bit is 1 and T1 is 0, which means the first segment is shorter than 2 quanta while triple sampling is selected.
- R10: A cycle with `bit_start` high gives no tick and no strobes. The next cycle starts quantum 0 with a fresh divider, so the next tick comes P+1 cycles after the `bit_start` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 prescaler, 1 timing |
| cfg_wdata | input | 8 | Write data |
| init_req | input | 1 | Initialization mode requested |
| init_ack | input | 1 | Initialization mode acknowledged |
| cfg_rdata | output | 8 | Selected register contents |
| bit_start | input | 1 | Restart the bit timer |
| rx_in | input | 1 | Received bus level |
| tq_tick | output | 1 | One-cycle time quantum tick |
| sample_valid | output | 1 | Sample point strobe |
| sample_bit | output | 1 | Resolved bit value, valid with `sample_valid` |
| bit_end | output | 1 | End-of-bit strobe |
| cfg_err | output | 1 | Triple sampling with too short a first segment |

## Verification
The bus level is driven steady low, steady high, toggling every cycle and as a pseudo-random sequence. Steady levels confirm the sample position does not matter when the bus is quiet. Toggling input separates an off-by-one sample cycle from the correct one. Random input under triple sampling tells a majority vote apart from a single sample. These patterns run under several prescaler and segment settings, including the largest segment values, and `bit_start` pulses are placed in the middle of bits. A write attempted with only one of the two initialization signals high shows the lock at the read port.

// File: rtl/can_bit_sampler.sv
module can_bit_sampler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  input  logic       init_req,
  input  logic       init_ack,
  output logic [7:0] cfg_rdata,
  input  logic       bit_start,
  input  logic       rx_in,
  output logic       tq_tick,
  output logic       sample_valid,
  output logic       sample_bit,
  output logic       bit_end,
  output logic       cfg_err
);
  logic [5:0] pre_q;
  logic [7:0] tim_q;
  logic [5:0] pc_q;
  logic [4:0] qn_q;
  logic [1:0] sh_q;

  logic       wr_ok, triple, maj;
  logic [4:0] last_qn, samp_qn;

  assign wr_ok   = cfg_wr & init_req & init_ack;
  assign triple  = tim_q[7];
  assign last_qn = 5'(tim_q[3:0]) + 5'(tim_q[6:4]) + 5'd2;
  assign samp_qn = 5'(tim_q[3:0]) + 5'd1;

  assign cfg_rdata = cfg_sel ? tim_q : {2'b00, pre_q};
  assign cfg_err   = triple & (tim_q[3:0] == 4'd0);

  assign tq_tick      = (pc_q == pre_q) & ~bit_start;
  assign sample_valid = tq_tick & (qn_q == samp_qn);
  assign bit_end      = tq_tick & (qn_q == last_qn);

  assign maj        = (sh_q[1] & sh_q[0]) | (sh_q[1] & rx_in) | (sh_q[0] & rx_in);
  assign sample_bit = triple ? maj : rx_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      tim_q <= '0;
    end else if (wr_ok) begin
      if (cfg_sel) tim_q <= cfg_wdata;
      else         pre_q <= cfg_wdata[5:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      qn_q <= '0;
      sh_q <= '0;
    end else if (bit_start) begin
      pc_q <= '0;
      qn_q <= '0;
    end else if (tq_tick) begin
      pc_q <= '0;
      qn_q <= bit_end ? 5'd0 : qn_q + 5'd1;
      sh_q <= {sh_q[0], rx_in};
    end else begin
      pc_q <= pc_q + 6'd1;
    end
  end
endmodule

// File: rtl/can_bit_sampler_chk.sv
module can_bit_sampler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tq_tick,
  input logic       sample_valid,
  input logic       bit_end,
  input logic       bit_start,
  input logic       wr_ok,
  input logic [5:0] pre_q,
  input logic [7:0] tim_q
);
  p_sample_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> tq_tick);
  p_end_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> tq_tick);
  p_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> ($stable(pre_q) && $stable(tim_q)));
  p_start_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |-> !tq_tick);
  p_start_no_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> (!bit_end && !sample_valid));
endmodule

bind can_bit_sampler can_bit_sampler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .sample_valid(sample_valid),
  .bit_end(bit_end), .bit_start(bit_start), .wr_ok(wr_ok),
  .pre_q(pre_q), .tim_q(tim_q)
);

// File: tb/test_can_bit_sampler.sv
module test_can_bit_sampler;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_sel = 0, init_req = 0, init_ack = 0;
  logic [7:0] cfg_wdata = 0;
  logic bit_start = 0, rx_in = 0;
  logic [7:0] cfg_rdata;
  logic tq_tick, sample_valid, sample_bit, bit_end, cfg_err;

  always #5 clk = ~clk;

  can_bit_sampler i_can_bit_sampler (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .init_req(init_req), .init_ack(init_ack),
    .cfg_rdata(cfg_rdata), .bit_start(bit_start), .rx_in(rx_in),
    .tq_tick(tq_tick), .sample_valid(sample_valid), .sample_bit(sample_bit),
    .bit_end(bit_end), .cfg_err(cfg_err)
  );

  int checks = 0, failures = 0;
  bit compare_on = 0;

  // behavioural reference model
  int m_pre = 0, m_t1 = 0, m_t2 = 0, m_samp = 0;
  int m_pc = 0, m_qn = 0;
  bit m_hist[$];

  function automatic bit exp_tick();
    return (m_pc == m_pre) && !bit_start;
  endfunction

  function automatic bit exp_bit();
    int ones;
    if (m_samp == 0) return rx_in;
    ones = int'(m_hist[0]) + int'(m_hist[1]) + int'(rx_in);
    return ones >= 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_t1 = 0; m_t2 = 0; m_samp = 0; m_pc = 0; m_qn = 0;
      m_hist = '{0, 0};
    end else begin
      bit tk;
      int nbt;
      tk  = exp_tick();
      nbt = 3 + m_t1 + m_t2;
      if (bit_start) begin
        m_pc = 0; m_qn = 0;
      end else if (tk) begin
        m_pc = 0;
        m_qn = (m_qn == nbt - 1) ? 0 : (m_qn + 1) % 32;
        void'(m_hist.pop_front());
        m_hist.push_back(rx_in);
      end else begin
        m_pc = (m_pc + 1) % 64;
      end
      if (cfg_wr && init_req && init_ack) begin
        if (cfg_sel) begin
          m_samp = cfg_wdata[7]; m_t2 = cfg_wdata[6:4]; m_t1 = cfg_wdata[3:0];
        end else m_pre = cfg_wdata[5:0];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      bit tk, sv;
      int exp_rd;
      tk = exp_tick();
      sv = tk && (m_qn == m_t1 + 1);
      chk("R4 tq_tick", tq_tick, tk);
      chk("R6 sample_valid", sample_valid, sv);
      chk("R5 bit_end", bit_end, tk && (m_qn == 2 + m_t1 + m_t2));
      if (sv) chk(m_samp ? "R8 sample_bit" : "R7 sample_bit", sample_bit, exp_bit());
      chk("R9 cfg_err", cfg_err, (m_samp == 1) && (m_t1 == 0));
      exp_rd = cfg_sel ? (m_samp * 128 + m_t2 * 16 + m_t1) : m_pre;
      chk("R3 cfg_rdata", cfg_rdata, exp_rd);
    end
  end

  task automatic wr(input bit sel, input logic [7:0] d, input bit rq, input bit ak);
    @(posedge clk); #1;
    cfg_sel = sel; cfg_wdata = d; cfg_wr = 1; init_req = rq; init_ack = ak;
    @(posedge clk); #1;
    cfg_wr = 0; init_req = 0; init_ack = 0;
  endtask

  task automatic run(input int n, input int mode);
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      case (mode)
        0: rx_in = 0;
        1: rx_in = 1;
        2: rx_in = ~rx_in;
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          rx_in = lfsr[0];
        end
      endcase
      bit_start = (i % 97) == 45;
    end
    @(posedge clk); #1; bit_start = 0;
  endtask

  task automatic start_gap(input int p);
    int cnt;
    @(posedge clk); #1; bit_start = 1;
    @(posedge clk); #1; bit_start = 0;
    cnt = 1;
    while (1) begin
      @(negedge clk);
      if (tq_tick || cnt > 200) break;
      @(posedge clk); #1; cnt++;
    end
    chk("R10 tick gap after bit_start", cnt, p + 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cfg_sel = 0;
    #1 chk("R1 prescaler reset", cfg_rdata, 0);
    cfg_sel = 1;
    #1 chk("R1 timing reset", cfg_rdata, 0);
    rst_n = 1;
    compare_on = 1;
    run(20, 2);
    for (int m = 0; m < 4; m++) begin
      wr(1, 8'h01, 1, 1); wr(0, 8'h00, 1, 1); run(150, m);
      wr(1, 8'hA3, 1, 1); wr(0, 8'h02, 1, 1); run(300, m);
      wr(1, 8'h7F, 1, 1); wr(0, 8'h05, 1, 1); run(600, m);
      wr(1, 8'h94, 1, 1); wr(0, 8'h01, 1, 1); run(300, m);
    end
    wr(1, 8'h80, 1, 1); run(60, 3);
    chk("R9 flag raised", cfg_err, 1);
    wr(1, 8'h25, 0, 1);
    wr(0, 8'h3F, 1, 0);
    cfg_sel = 1; #1 chk("R2 timing locked", cfg_rdata, 8'h80);
    cfg_sel = 0; #1 chk("R2 prescaler locked", cfg_rdata, 8'h01);
    wr(0, 8'hFF, 1, 1);
    #1 chk("R3 prescaler top bits zero", cfg_rdata, 8'h3F);
    wr(0, 8'h04, 1, 1); wr(1, 8'h32, 1, 1);
    run(40, 3);
    start_gap(4);
    run(30, 2);
    wr(0, 8'h00, 1, 1);
    start_gap(0);
    run(20, 1);
    compare_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule